// File: doc/BRIEF.md
# Dual Receive Buffer with Destination Filter

This block is the receive half of a small Ethernet MAC. Frame bytes arrive one per cycle with a valid strobe and a last marker. The block reads the six destination bytes first. It accepts the frame if the frame is addressed to a group or if it matches the station address. Accepted frames are copied into one of two receive buffers. Software reads these buffers over a 32-bit register bus and hands each buffer back by clearing its full flag. When a frame has been stored, the block can raise a one-cycle interrupt pulse.

The first six bytes are held inside the block until the filter decision is made. The decision is taken on the sixth byte. An optional ping-pong mode alternates between the two buffers after every stored frame. Without it, every frame goes to buffer 0. After the last byte of a frame, the source leaves at least one cycle with `rx_valid` low.

The receive sequencer has five states:
- IDLE waits for a first byte.
  - A one-byte frame keeps it in IDLE.
  - Otherwise it moves to HEAD.
- HEAD collects the destination bytes.
  - A last byte before the sixth returns it to IDLE.
  - On the sixth byte it moves to STORE (kept, more to come), to FIN (kept, last byte), to DROP (refused, more to come) or to IDLE (refused, last byte).
- STORE writes full words and goes to FIN on the last byte.
- DROP discards bytes until the last one, then returns to IDLE.
- FIN writes the final partial word, marks the buffer full, may pulse the interrupt, selects the next buffer and returns to IDLE.

Top module: `rx_pingpong_buf`

## Requirements
- R1: The bus offset `bus_addr` uses the following map:
  - Buffer 0 data starts at 0x1000 and its control word is at 0x17FC.
  - Buffer 1 data starts at 0x1800 and its control word is at 0x1FFC.
  - Reads return data one cycle after the address is presented.
  - Bus writes to buffer data words are ignored.
- R2: A frame is accepted when bit 7 of its first byte is 1, or when its six destination bytes equal `station_addr` (bits 47:40 compared with the first byte). Any other frame, and any frame shorter than six bytes, leaves both buffers, both control words and the interrupt untouched.
- R3: If the full flag S (control bit 0) of the active buffer is set when the sixth byte arrives, the frame is lost. Neither buffer changes, no interrupt is raised and the active buffer stays the same.
- R4: An accepted frame is written from data word 0 of the active buffer. Bytes are packed least significant byte first within each word, and the unused upper bytes of the last word read as zero. S is set once the frame is stored.
- R5: After a frame is stored, `irq` pulses high for exactly one cycle if bit 3 (I) of that buffer's control word and `irq_enable` are both 1. Otherwise it stays low.
- R6: With `pingpong_en` high, the active buffer toggles after each stored frame. With it low, buffer 0 is selected after each stored frame.
- R7: A software write to a control word clears S when bit 0 of the data is 0 and never sets S. All other bits are stored as written.
- R8: Bytes beyond 2044 are not stored, and the control word is never overwritten by frame data.
- R9: When a software control write meets the storing of a frame in the same cycle:
  - S ends set.
  - The other bits take the written value.
  - The interrupt decision uses the I bit held before that cycle.
- R10: After reset, both control words read 0, buffer 0 is active and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Incoming frame byte |
| rx_valid | input | 1 | Byte strobe |
| rx_last | input | 1 | Marks the final byte of a frame |
| station_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| pingpong_en | input | 1 | Alternate between the two buffers |
| irq_enable | input | 1 | Global interrupt enable |
| bus_addr | input | 13 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq | output | 1 | Frame-stored interrupt pulse |

## Verification
The closing FIN step of a frame and a software write to that buffer's control word can fall in the same cycle. Both then try to change the same control word. The bench provokes this by lowering `rx_valid` after the last byte and, at that same falling edge, presenting a control write with S=0, I=0 and some other bits set. It then judges the result three ways:
- the read-back control word must show S set together with exactly the written other bits;
- an interrupt pulse must still be seen, because I was set before the write;
- the stored data must match the frame.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HEAD  = 3'd1,
        ST_STORE = 3'd2,
        ST_DROP  = 3'd3,
        ST_FIN   = 3'd4
    } rx_state_e;

    localparam int CTRL_S_BIT = 0;   // buffer full flag
    localparam int CTRL_I_BIT = 3;   // per-buffer interrupt enable
    localparam int HDR_BYTES  = 6;   // destination address length

endpackage

// File: rtl/rxpp_addr_match.sv
module rxpp_addr_match #(
    parameter int ADDR_W = 48
) (
    input  logic [31:0]       hdr_word0,
    input  logic [7:0]        byte4,
    input  logic [7:0]        byte5,
    input  logic [ADDR_W-1:0] station_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] dest;

    // Reassemble wire order: first byte into the top bits.
    assign dest = {hdr_word0[7:0], hdr_word0[15:8], hdr_word0[23:16],
                   hdr_word0[31:24], byte4, byte5};

    assign hit = dest[ADDR_W-1] || (dest == station_addr);
endmodule

// File: rtl/rxpp_fsm.sv
module rxpp_fsm
    import rxpp_pkg::*;
#(
    parameter int DATA_BYTES = 2044,
    parameter int WIDX_W     = 9,
    parameter int CNT_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_last,
    input  logic              addr_hit,
    input  logic              act_full,
    output logic [31:0]       hdr_word0,
    output logic [7:0]        hdr_byte4,
    output logic              wr_en,
    output logic [WIDX_W-1:0] wr_idx,
    output logic [31:0]       wr_data,
    output logic              commit,
    output rx_state_e         state_o
);
    rx_state_e         state, state_nx;
    logic [CNT_W-1:0]  bcnt;
    logic [31:0]       acc, hdr0, pend;
    logic [WIDX_W-1:0] pend_idx;
    logic              pend_ok;
    logic [31:0]       acc_ins;
    logic              storable, word_done, keep, at_decide, take;

    assign acc_ins   = acc | ({24'd0, rx_data} << {bcnt[1:0], 3'b000});
    assign storable  = (bcnt < CNT_W'(DATA_BYTES));
    assign word_done = (bcnt[1:0] == 2'd3);
    assign keep      = addr_hit && !act_full;
    assign at_decide = (bcnt == CNT_W'(HDR_BYTES - 1));
    assign take      = rx_valid && (state != ST_FIN);

    assign hdr_word0 = hdr0;
    assign hdr_byte4 = acc[7:0];
    assign state_o   = state;

    // Next state and write requests
    always_comb begin
        state_nx = state;
        wr_en    = 1'b0;
        wr_idx   = bcnt[WIDX_W+1:2];
        wr_data  = acc_ins;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rx_valid) state_nx = rx_last ? ST_IDLE : ST_HEAD;
            end
            ST_HEAD: begin
                if (rx_valid) begin
                    if (at_decide) begin
                        if (keep) begin
                            wr_en    = 1'b1;
                            wr_idx   = '0;
                            wr_data  = hdr0;
                            state_nx = rx_last ? ST_FIN : ST_STORE;
                        end else begin
                            state_nx = rx_last ? ST_IDLE : ST_DROP;
                        end
                    end else if (rx_last) begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_STORE: begin
                if (rx_valid) begin
                    if (rx_last)                     state_nx = ST_FIN;
                    else if (storable && word_done)  wr_en = 1'b1;
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_last) state_nx = ST_IDLE;
            end
            ST_FIN: begin
                wr_en    = pend_ok;
                wr_idx   = pend_idx;
                wr_data  = pend;
                commit   = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and byte packing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bcnt     <= '0;
            acc      <= '0;
            hdr0     <= '0;
            pend     <= '0;
            pend_idx <= '0;
            pend_ok  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_FIN) begin
                bcnt <= '0;
                acc  <= '0;
            end else if (take) begin
                if (rx_last) begin
                    pend     <= storable ? acc_ins : acc;
                    pend_ok  <= storable;
                    pend_idx <= bcnt[WIDX_W+1:2];
                    bcnt     <= '0;
                    acc      <= '0;
                end else begin
                    if (storable) begin
                        acc  <= word_done ? '0 : acc_ins;
                        bcnt <= bcnt + 1'b1;
                    end
                    if (state == ST_HEAD && bcnt == CNT_W'(3)) hdr0 <= acc_ins;
                end
            end
        end
    end
endmodule

// File: rtl/rxpp_bank.sv
module rxpp_bank
    import rxpp_pkg::*;
#(
    parameter int BUF_WORDS = 512,
    parameter int WIDX_W    = 9,
    parameter int ADDR_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              commit,
    input  logic              pingpong_en,
    input  logic              irq_enable,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              act,
    output logic              act_full,
    output logic [1:0]        full
);
    localparam int          NBUF     = 2;
    localparam int          CTRL_IDX = BUF_WORDS - 1;
    localparam logic [31:0] S_MASK   = 32'h1 << CTRL_S_BIT;

    logic              region, bsel;
    logic [WIDX_W-1:0] bw;
    logic [1:0][31:0]  ctrl_all;
    logic [31:0]       mem [0:NBUF*BUF_WORDS-1];

    assign region = bus_addr[ADDR_W-1];
    assign bsel   = bus_addr[ADDR_W-2];
    assign bw     = bus_addr[ADDR_W-3:2];

    always_ff @(posedge clk) begin
        if (wr_en) mem[{act, wr_idx}] <= wr_data;
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_ctrl
        logic [31:0] ctrl_r;
        logic        hw_set, sw_hit;
        assign hw_set = commit && (act == 1'(g));
        assign sw_hit = bus_we && region && (bsel == 1'(g)) && (bw == WIDX_W'(CTRL_IDX));
        always_ff @(posedge clk) begin
            if (!rst_n)      ctrl_r <= '0;
            else if (sw_hit) ctrl_r <= (bus_wdata & ~S_MASK)
                                     | (bus_wdata & ctrl_r & S_MASK)
                                     | (hw_set ? S_MASK : 32'd0);
            else if (hw_set) ctrl_r <= ctrl_r | S_MASK;
        end
        assign ctrl_all[g] = ctrl_r;
        assign full[g]     = ctrl_r[CTRL_S_BIT];
    end

    assign act_full = ctrl_all[act][CTRL_S_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            act       <= 1'b0;
            bus_rdata <= '0;
        end else begin
            irq <= commit && ctrl_all[act][CTRL_I_BIT] && irq_enable;
            if (commit) act <= pingpong_en ? ~act : 1'b0;
            if (!region)                         bus_rdata <= '0;
            else if (bw == WIDX_W'(CTRL_IDX))   bus_rdata <= ctrl_all[bsel];
            else                                 bus_rdata <= mem[{bsel, bw}];
        end
    end
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf
    import rxpp_pkg::*;
#(
    parameter int BUF_WORDS = 512,
    parameter int WIDX_W    = $clog2(BUF_WORDS),
    parameter int ADDR_W    = WIDX_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_last,
    input  logic [47:0]       station_addr,
    input  logic              pingpong_en,
    input  logic              irq_enable,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int DATA_BYTES = (BUF_WORDS - 1) * 4;
    localparam int CNT_W      = WIDX_W + 2;

    logic [31:0]       hdr_word0;
    logic [7:0]        hdr_byte4;
    logic              addr_hit, act, act_full, wr_en, commit;
    logic [WIDX_W-1:0] wr_idx;
    logic [31:0]       wr_data;
    logic [1:0]        full;
    rx_state_e         fsm_state;

    rxpp_addr_match #(.ADDR_W(48)) u_match (
        .hdr_word0    (hdr_word0),
        .byte4        (hdr_byte4),
        .byte5        (rx_data),
        .station_addr (station_addr),
        .hit          (addr_hit)
    );

    rxpp_fsm #(.DATA_BYTES(DATA_BYTES), .WIDX_W(WIDX_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .addr_hit  (addr_hit),
        .act_full  (act_full),
        .hdr_word0 (hdr_word0),
        .hdr_byte4 (hdr_byte4),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .commit    (commit),
        .state_o   (fsm_state)
    );

    rxpp_bank #(.BUF_WORDS(BUF_WORDS), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .commit      (commit),
        .pingpong_en (pingpong_en),
        .irq_enable  (irq_enable),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq         (irq),
        .act         (act),
        .act_full    (act_full),
        .full        (full)
    );
endmodule

// File: rtl/rxpp_checker.sv
module rxpp_checker
    import rxpp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       irq_enable,
    input logic       pingpong_en,
    input logic       act,
    input logic       act_full,
    input logic       wr_en,
    input logic       wr_ctrl_slot,
    input logic [1:0] full,
    input logic [2:0] state
);
    logic fin;
    assign fin = (state == ST_FIN);

    // R5: a pulse needs the global enable at the storing cycle
    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_enable));

    // R5: pulse lasts one cycle
    a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: a pulse is only seen once a buffer is marked full
    a_r4_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (full != 2'b00));

    // R6: the active buffer only changes right after a stored frame
    a_r6_switch_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> $past(fin));

    // R6: without alternation buffer 0 follows every stored frame
    a_r6_fixed_without_pp: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !pingpong_en) |=> !act);

    // R3: nothing is written into a buffer that is full
    a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !act_full);

    // R8: frame data never lands on the control slot
    a_r8_ctrl_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wr_ctrl_slot);
endmodule

bind rx_pingpong_buf rxpp_checker u_rxpp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .irq_enable   (irq_enable),
    .pingpong_en  (pingpong_en),
    .act          (act),
    .act_full     (act_full),
    .wr_en        (wr_en),
    .wr_ctrl_slot (&wr_idx),
    .full         (full),
    .state        (fsm_state)
);

// File: tb/tb_rx_pingpong_buf.sv
module tb_rx_pingpong_buf;
    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam int          DWMAX = 511;
    localparam int          BMAX  = 2044;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic        pingpong_en = 1'b1, irq_enable = 1'b1;
    logic [12:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0, checks = 0, cycles = 0, irq_cnt = 0;
    logic [31:0] exp_mem [2][DWMAX];
    bit          exp_ok  [2][DWMAX];
    logic [31:0] exp_ctrl [2];
    logic        m_act = 1'b0;

    always #5 clk = ~clk;

    rx_pingpong_buf dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_last(rx_last), .station_addr(STA), .pingpong_en(pingpong_en),
        .irq_enable(irq_enable), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(negedge clk) if (irq === 1'b1) irq_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // {pp, gie, ibit, release[1:0], kind[1:0], 2'b0, len[11:0]}
    // kind 0: station match, 1: group, 2: mismatch in last address byte
    localparam logic [20:0] VEC [12] = '{
        {1'b1, 1'b1, 1'b1, 2'b11, 2'd0, 2'b00, 12'd20},
        {1'b1, 1'b1, 1'b1, 2'b00, 2'd1, 2'b00, 12'd9},
        {1'b1, 1'b1, 1'b1, 2'b00, 2'd0, 2'b00, 12'd15},
        {1'b1, 1'b1, 1'b1, 2'b01, 2'd2, 2'b00, 12'd30},
        {1'b1, 1'b1, 1'b1, 2'b00, 2'd2, 2'b00, 12'd6},
        {1'b1, 1'b1, 1'b1, 2'b00, 2'd0, 2'b00, 12'd6},
        {1'b1, 1'b1, 1'b1, 2'b10, 2'd1, 2'b00, 12'd2100},
        {1'b1, 1'b1, 1'b1, 2'b01, 2'd0, 2'b00, 12'd4},
        {1'b1, 1'b0, 1'b1, 2'b01, 2'd0, 2'b00, 12'd33},
        {1'b0, 1'b1, 1'b0, 2'b11, 2'd1, 2'b00, 12'd17},
        {1'b0, 1'b1, 1'b1, 2'b01, 2'd0, 2'b00, 12'd8},
        {1'b0, 1'b1, 1'b1, 2'b00, 2'd1, 2'b00, 12'd10}
    };

    function automatic logic [7:0] fbyte(input int kind, input int seed, input int i);
        if (i < 6) begin
            case (kind)
                0: return STA[47-8*i -: 8];
                1: return (i == 0) ? 8'h81 : 8'(8'hA0 + i);
                default: return (i == 5) ? (STA[7:0] ^ 8'h01) : STA[47-8*i -: 8];
            endcase
        end
        return 8'(seed * 37 + i * 5 + (i >> 8));
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, a, e);
        end
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a;
        @(negedge clk); d = bus_rdata;
    endtask

    function automatic logic [12:0] ctrl_addr(input int b);
        return 13'h17FC | 13'(b << 11);
    endfunction

    function automatic logic [12:0] data_addr(input int b, input int w);
        return 13'h1000 | 13'(b << 11) | 13'(w << 2);
    endfunction

    task automatic send_frame(input int len, input int kind, input int seed,
                              input bit collide, input int cb, input logic [31:0] cw);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fbyte(kind, seed, i); rx_last = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        if (collide) begin
            bus_addr = ctrl_addr(cb); bus_wdata = cw; bus_we = 1'b1;
            @(negedge clk); bus_we = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic model_store(input int b, input int len, input int kind, input int seed);
        int n = (len > BMAX) ? BMAX : len;
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] word = '0;
            for (int k = 0; k < 4; k++)
                if (w * 4 + k < n) word[k*8 +: 8] = fbyte(kind, seed, w * 4 + k);
            exp_mem[b][w] = word;
            exp_ok[b][w]  = 1'b1;
        end
    endtask

    task automatic check_state(input string tag);
        logic [31:0] d;
        for (int b = 0; b < 2; b++) begin
            int bad = 0;
            logic [31:0] fa = '0, fe = '0;
            bus_read(ctrl_addr(b), d);
            chk(d === exp_ctrl[b], $sformatf("%s ctrl%0d", tag, b), d, exp_ctrl[b]);
            for (int w = 0; w < DWMAX; w++) begin
                if (exp_ok[b][w]) begin
                    bus_read(data_addr(b, w), d);
                    if (d !== exp_mem[b][w]) begin
                        if (bad == 0) begin fa = d; fe = exp_mem[b][w]; end
                        bad++;
                    end
                end
            end
            chk(bad == 0, $sformatf("%s R4 R8 data buf%0d", tag, b), fa, fe);
        end
    endtask

    initial begin
        logic [31:0] d;
        for (int b = 0; b < 2; b++) begin
            exp_ctrl[b] = '0;
            for (int w = 0; w < DWMAX; w++) exp_ok[b][w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        bus_read(ctrl_addr(0), d); chk(d === 32'd0, "R10 ctrl0 after reset", d, 32'd0);
        bus_read(ctrl_addr(1), d); chk(d === 32'd0, "R10 ctrl1 after reset", d, 32'd0);
        chk(irq === 1'b0, "R10 irq after reset", {31'd0, irq}, 32'd0);

        // Table of frames: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 12; v++) begin
            logic [20:0] e = VEC[v];
            int  len  = int'(e[11:0]);
            int  kind = int'(e[15:14]);
            bit  stored;
            int  exp_irq = 0;
            int  tb;
            pingpong_en = e[20];
            irq_enable  = e[19];
            for (int b = 0; b < 2; b++) begin
                if (e[16 + b]) begin
                    bus_write(ctrl_addr(b), {28'd0, e[18], 3'b000});
                    exp_ctrl[b] = {28'd0, e[18], 3'b000};
                end
            end
            stored = (len >= 6) && (kind != 2) && !exp_ctrl[m_act][0];
            tb = int'(m_act);
            if (stored) begin
                exp_irq = (exp_ctrl[tb][3] && e[19]) ? 1 : 0;
                exp_ctrl[tb][0] = 1'b1;
                model_store(tb, len, kind, v);
                m_act = e[20] ? ~m_act : 1'b0;
            end
            irq_cnt = 0;
            send_frame(len, kind, v, 1'b0, 0, '0);
            chk(irq_cnt == exp_irq, $sformatf("R5 irq count vec%0d", v), irq_cnt, exp_irq);
            check_state($sformatf("R2 R3 R6 vec%0d", v));
        end

        // R9: control write lands on the storing cycle
        pingpong_en = 1'b1; irq_enable = 1'b1;
        for (int b = 0; b < 2; b++) begin
            bus_write(ctrl_addr(b), 32'h8);
            exp_ctrl[b] = 32'h8;
        end
        begin
            int tb = int'(m_act);
            model_store(tb, 12, 0, 40);
            exp_ctrl[tb] = 32'hF1;
            m_act = ~m_act;
            irq_cnt = 0;
            send_frame(12, 0, 40, 1'b1, tb, 32'h0000_00F0);
            chk(irq_cnt == 1, "R9 irq uses prior I bit", irq_cnt, 1);
            check_state("R9 collision");
        end

        // R1: bus writes to data words are ignored
        bus_write(data_addr(0, 0), 32'hDEAD_BEEF);
        bus_read(data_addr(0, 0), d);
        chk(d === exp_mem[0][0], "R1 data word write ignored", d, exp_mem[0][0]);

        // R7: software cannot set S, other bits kept
        bus_write(ctrl_addr(1), 32'h0000_0008);
        bus_write(ctrl_addr(1), 32'h0000_0029);
        bus_read(ctrl_addr(1), d);
        chk(d === 32'h28, "R7 S not settable by software", d, 32'h28);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule